// File: doc/BRIEF.md
# Programmable Trigger-Sense Conditioner

This block conditions a wide set of asynchronous request lines before they reach an interrupt controller. Every line is brought into the clock domain by a two-flop synchroniser. It then passes through one of four sense modes, chosen by two configuration bits for that line. The result is a conditioned vector that the controller samples. In the two edge modes the line drives a sticky latch, which software acknowledges by writing ones. In the two level modes the synchronised line passes straight through, and is inverted for active-low.

Software reaches the block through a simple register port. The write side has a one-cycle strobe. The read side is combinational. Lines are grouped into banks of 32. Each bank has a 32-byte window, and bank b starts at byte offset 0x20·b. Address bits [4:2] pick the register within a bank:

| Offset | Register |
|---|---|
| 0x00 | conditioned status (read-only; writes are dropped) |
| 0x04 | latched edge status (writing 1 acknowledges) |
| 0x08 | rise configuration |
| 0x0C | fall configuration |
| 0x10 | set rise bits |
| 0x14 | clear rise bits |
| 0x18 | set fall bits |
| 0x1C | clear fall bits |

Each line runs as a four-state machine driven by its pair {rise,fall}:

| Pair | State | Behaviour |
|---|---|---|
| 00 | `SENSE_LVL_HI` | active-high level |
| 01 | `SENSE_FALL` | falling edge |
| 10 | `SENSE_RISE` | rising edge |
| 11 | `SENSE_LVL_LO` | active-low level |

Every transition between these states happens on a configuration write that changes the pair. Each such transition clears the line's latch.

Top module: `trig_cond_unit`

## Requirements
- R1: After reset, every rise and fall configuration bit reads 0, so every line is in `SENSE_LVL_HI`, and every latched edge status bit reads 0.
- R2: In `SENSE_LVL_HI` (pair 00), the line's status bit (offset 0x00, bit = line mod 32) and its `trig_out` bit equal the input two clock edges after the input changes, and read the old value after one edge.
- R3: In `SENSE_LVL_LO` (pair 11), the status bit is the inverse of the synchronised input.
- R4: In `SENSE_RISE` (pair 10), a 0→1 input change sets the latched edge bit (offset 0x04) three clock edges after the input change, and not after two. The status bit and `trig_out` then show the latch.
- R5: In `SENSE_FALL` (pair 01), a 1→0 input change sets the latched edge bit with the same three-edge latency.
- R6: A latched edge bit stays set after the input returns to its idle value. Writing 1 to it at offset 0x04 clears it on the write edge. Writing 0 leaves it unchanged.
- R7: If an edge is detected in the same cycle as an acknowledge write for that line, the bit stays set.
- R8: Writes to 0x10/0x18 set, and writes to 0x14/0x1C clear, only the rise or fall bits written as 1. Writes to 0x08/0x0C replace the whole bank's bits. The bits read back at 0x08 and 0x0C.
- R9: Any write that changes a line's {rise,fall} pair clears that line's latch on the write edge. Selecting an edge mode while the input already sits at its post-edge level produces no latch.
- R10: Lines 32..63 are served at byte offsets 0x20..0x3C and never show up in the bank at 0x00..0x1C.
- R11: Writes to the status offset have no effect. Lines in the level modes never set their latched edge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| irq_in | input | 64 | asynchronous request lines |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 6 | write byte address |
| wr_data | input | 32 | write data |
| rd_addr | input | 6 | read byte address |
| rd_data | output | 32 | read data (combinational) |
| trig_out | output | 64 | conditioned trigger vector |

## Verification
A level-mode result is due two clock edges after the input moves: one edge for each synchroniser stage. An edge-mode result is due three edges after the input moves, because the latch adds one more edge. Configuration and acknowledge writes take effect on the single edge that the write strobe covers. The bench changes inputs on falling edges and counts rising edges one by one. It reads at the falling edge just before and just after each result is due, so an extra or a missing register stage shows as a wrong value. For the same-cycle race, the acknowledge write is timed to cover exactly the edge on which the latch sets.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
    // Encoding is {rise, fall}
    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_FALL   = 2'b01,
        SENSE_RISE   = 2'b10,
        SENSE_LVL_LO = 2'b11
    } sense_e;

    // Register select within a bank, from byte address bits [4:2]
    typedef enum logic [2:0] {
        REG_STATUS   = 3'd0,
        REG_RAW      = 3'd1,
        REG_RISE     = 3'd2,
        REG_FALL     = 3'd3,
        REG_RISE_SET = 3'd4,
        REG_RISE_CLR = 3'd5,
        REG_FALL_SET = 3'd6,
        REG_FALL_CLR = 3'd7
    } reg_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_out  <= '0;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/trig_cfg.sv
module trig_cfg
    import trig_cond_pkg::*;
#(
    parameter int N      = 64,
    parameter int BANK_W = 32,
    parameter int NB     = 2,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BANK_W-1:0] wr_data,
    output logic [N-1:0]      rise_q,
    output logic [N-1:0]      fall_q,
    output logic [N-1:0]      cfg_chg,
    output logic [N-1:0]      ack
);
    reg_e         wreg;
    logic [N-1:0] sel;
    logic [N-1:0] wide;
    logic [N-1:0] rise_n;
    logic [N-1:0] fall_n;

    assign wreg = reg_e'(wr_addr[4:2]);

    for (genvar b = 0; b < NB; b++) begin : g_bank_sel
        assign sel[b*BANK_W +: BANK_W] =
            (32'(wr_addr[AW-1:5]) == b) ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
    end

    assign wide = {NB{wr_data}} & sel;

    always_comb begin
        rise_n = rise_q;
        fall_n = fall_q;
        ack    = '0;
        if (wr_en) begin
            unique case (wreg)
                REG_STATUS:   ;
                REG_RAW:      ack    = wide;
                REG_RISE:     rise_n = (rise_q & ~sel) | wide;
                REG_FALL:     fall_n = (fall_q & ~sel) | wide;
                REG_RISE_SET: rise_n = rise_q | wide;
                REG_RISE_CLR: rise_n = rise_q & ~wide;
                REG_FALL_SET: fall_n = fall_q | wide;
                REG_FALL_CLR: fall_n = fall_q & ~wide;
            endcase
        end
    end

    assign cfg_chg = (rise_n ^ rise_q) | (fall_n ^ fall_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= rise_n;
            fall_q <= fall_n;
        end
    end

    // R8: a set alias leaves every written-1 bit set
    assert_rise_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wreg == REG_RISE_SET) |=> ((rise_q & $past(wide)) == $past(wide)));
    // R8: a clear alias leaves every written-1 bit clear
    assert_fall_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wreg == REG_FALL_CLR) |=> ((fall_q & $past(wide)) == '0));
endmodule

// File: rtl/trig_line.sv
module trig_line
    import trig_cond_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   sync_in,
    input  logic   cfg_chg,
    input  logic   ack,
    output logic   hit_q,
    output logic   trig
);
    logic prev_q;
    logic edge_det;

    // Output and edge decode per sense state
    always_comb begin
        unique case (mode)
            SENSE_RISE: begin
                edge_det = sync_in & ~prev_q;
                trig     = hit_q;
            end
            SENSE_FALL: begin
                edge_det = ~sync_in & prev_q;
                trig     = hit_q;
            end
            SENSE_LVL_HI: begin
                edge_det = 1'b0;
                trig     = sync_in;
            end
            SENSE_LVL_LO: begin
                edge_det = 1'b0;
                trig     = ~sync_in;
            end
        endcase
    end

    // prev_q reloads from the synchronised input on every edge, which includes
    // the edge of a configuration change, so a new mode sees no stale edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            prev_q <= sync_in;
            if (cfg_chg) hit_q <= 1'b0;
            else         hit_q <= edge_det | (hit_q & ~ack);
        end
    end

    // R7: a detected edge sets the latch even when an acknowledge arrives with it
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && !cfg_chg) |=> hit_q);
    // R6: the latch holds without an acknowledge
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !ack && !cfg_chg) |=> hit_q);
    // R6: an acknowledge without an edge clears the latch
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !edge_det && !cfg_chg) |=> !hit_q);
    // R9: a mode change clears the latch
    assert_cfg_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !hit_q);
    // R11: level modes never hold a latched edge
    assert_level_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LVL_HI || mode == SENSE_LVL_LO) |-> !hit_q);
endmodule

// File: rtl/trig_cond_unit.sv
module trig_cond_unit
    import trig_cond_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int BANK_W    = 32,
    localparam int NB       = NUM_LINES / BANK_W,
    localparam int BANK_AW  = (NB > 1) ? $clog2(NB) : 1,
    localparam int ADDR_W   = 5 + BANK_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BANK_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BANK_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] trig_out
);
    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] rise_q;
    logic [NUM_LINES-1:0] fall_q;
    logic [NUM_LINES-1:0] cfg_chg;
    logic [NUM_LINES-1:0] ack;
    logic [NUM_LINES-1:0] hit_v;

    trig_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .d_out (sync_v)
    );

    trig_cfg #(.N(NUM_LINES), .BANK_W(BANK_W), .NB(NB), .AW(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rise_q  (rise_q),
        .fall_q  (fall_q),
        .cfg_chg (cfg_chg),
        .ack     (ack)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        trig_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (sense_e'({rise_q[i], fall_q[i]})),
            .sync_in (sync_v[i]),
            .cfg_chg (cfg_chg[i]),
            .ack     (ack[i]),
            .hit_q   (hit_v[i]),
            .trig    (trig_out[i])
        );
    end

    // Combinational read mux
    reg_e        rreg;
    int unsigned rbase;

    assign rreg  = reg_e'(rd_addr[4:2]);
    assign rbase = 32'(rd_addr[ADDR_W-1:5]) * BANK_W;

    always_comb begin
        rd_data = '0;
        if (rbase < NUM_LINES) begin
            unique case (rreg)
                REG_STATUS: rd_data = trig_out[rbase +: BANK_W];
                REG_RAW:    rd_data = hit_v[rbase +: BANK_W];
                REG_RISE:   rd_data = rise_q[rbase +: BANK_W];
                REG_FALL:   rd_data = fall_q[rbase +: BANK_W];
                REG_RISE_SET, REG_RISE_CLR, REG_FALL_SET, REG_FALL_CLR: rd_data = '0;
            endcase
        end
    end
endmodule

// File: tb/tb_trig_cond_unit.sv
module tb_trig_cond_unit;
    localparam logic [5:0] B0 = 6'h00;
    localparam logic [5:0] B1 = 6'h20;
    localparam logic [5:0] O_STAT = 6'h00, O_RAW = 6'h04, O_RISE = 6'h08, O_FALL = 6'h0C;
    localparam logic [5:0] O_RSET = 6'h10, O_FSET = 6'h18, O_FCLR = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] trig_out;

    int checks = 0;
    int failures = 0;
    int pending = 0;
    bit done = 0;

    typedef struct {
        logic [5:0]  a;
        logic [31:0] m;
        logic [31:0] e;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    trig_cond_unit dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .trig_out(trig_out)
    );

    // Monitor: pops expected reads and compares
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                item_t it;
                it = sb.pop_front();
                rd_addr = it.a;
                #1;
                checks++;
                if ((rd_data & it.m) !== it.e) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.a, rd_data & it.m, it.e);
                end
                pending--;
            end
        end
    end

    task automatic chk(input logic [5:0] a, input logic [31:0] m,
                       input logic [31:0] e, input string tag);
        item_t it;
        it.a = a; it.m = m; it.e = e; it.tag = tag;
        pending++;
        sb.push_back(it);
        wait (pending == 0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(B0 + O_RISE, '1, 32'h0, "R1 rise cfg");
        chk(B1 + O_FALL, '1, 32'h0, "R1 fall cfg");
        chk(B0 + O_RAW,  '1, 32'h0, "R1 raw");
        chk(B0 + O_STAT, '1, 32'h0, "R1 status");

        // R2 level-high on line 5
        irq_in[5] = 1'b1;
        cyc(1);
        chk(B0 + O_STAT, 32'h20, 32'h0, "R2 one edge");
        cyc(1);
        chk(B0 + O_STAT, 32'h20, 32'h20, "R2 two edges");

        // R3 / R8 line 7 to level-low with input low
        wr(B0 + O_RSET, 32'h80);
        wr(B0 + O_FSET, 32'h80);
        chk(B0 + O_STAT, 32'h80, 32'h80, "R3 inverted");
        chk(B0 + O_RISE, '1, 32'h80, "R8 rise set");
        chk(B0 + O_FALL, '1, 32'h80, "R8 fall set");

        // R4 rising edge on line 40 (bank 1 bit 8)
        wr(B1 + O_RSET, 32'h100);
        irq_in[40] = 1'b1;
        cyc(2);
        chk(B1 + O_RAW, 32'h100, 32'h0, "R4 not yet");
        cyc(1);
        chk(B1 + O_RAW, 32'h100, 32'h100, "R4 latched");
        chk(B1 + O_STAT, 32'h100, 32'h100, "R4 status");
        checks++;
        if (trig_out[40] !== 1'b1) begin
            failures++;
            $display("FAIL R4 trig_out[40] actual=%b expected=1", trig_out[40]);
        end
        chk(B0 + O_RAW, 32'h100, 32'h0, "R10 bank isolation");
        irq_in[40] = 1'b0;
        cyc(4);
        chk(B1 + O_RAW, 32'h100, 32'h100, "R6 sticky");

        // R6 acknowledge
        wr(B1 + O_RAW, 32'hFFFF_FEFF);
        chk(B1 + O_RAW, 32'h100, 32'h100, "R6 zero no effect");
        wr(B1 + O_RAW, 32'h100);
        chk(B1 + O_RAW, 32'h100, 32'h0, "R6 cleared");
        chk(B1 + O_STAT, 32'h100, 32'h0, "R6 status cleared");

        // R5 falling edge on line 12
        irq_in[12] = 1'b1;
        cyc(3);
        wr(B0 + O_FSET, 32'h1000);
        irq_in[12] = 1'b0;
        cyc(2);
        chk(B0 + O_RAW, 32'h1000, 32'h0, "R5 not yet");
        cyc(1);
        chk(B0 + O_RAW, 32'h1000, 32'h1000, "R5 latched");

        // R9 mode change clears latch
        wr(B0 + O_RSET, 32'h1000);
        chk(B0 + O_RAW, 32'h1000, 32'h0, "R9 cleared by mode change");
        chk(B0 + O_STAT, 32'h1000, 32'h1000, "R9 level-low state");
        wr(B0 + O_FCLR, 32'h1000);
        cyc(3);
        chk(B0 + O_RAW, 32'h1000, 32'h0, "R9 no spurious");
        irq_in[20] = 1'b1;
        cyc(3);
        wr(B0 + O_RSET, 32'h10_0000);
        cyc(3);
        chk(B0 + O_RAW, 32'h10_0000, 32'h0, "R9 already high");

        // R7 edge coincides with acknowledge on line 12
        irq_in[12] = 1'b1;
        cyc(2);
        wr(B0 + O_RAW, 32'h1000);
        chk(B0 + O_RAW, 32'h1000, 32'h1000, "R7 edge wins");

        // R11 status writes dropped, level lines never latch
        wr(B0 + O_STAT, 32'hFFFF_FFFF);
        chk(B0 + O_STAT, 32'hA0, 32'hA0, "R11 status write ignored");
        chk(B0 + O_RISE, '1, 32'h10_1080, "R11 config untouched");
        irq_in[5] = 1'b0;
        cyc(3);
        chk(B0 + O_RAW, 32'h20, 32'h0, "R11 level no latch");
        chk(B0 + O_STAT, 32'h20, 32'h0, "R2 follows low");

        // R8 direct write replaces bank
        wr(B0 + O_FALL, 32'h0);
        chk(B0 + O_FALL, '1, 32'h0, "R8 direct write");
        chk(B0 + O_STAT, 32'h80, 32'h0, "R8 line7 now rising");

        finish_run();
    end
endmodule